// File: doc/BRIEF.md
# SHA-256 Multi-Block Compression Engine

This block runs the SHA-256 compression function over one or more 512-bit message blocks for each start command. It keeps the eight-word chaining state and the eight working variables a..h. A message-schedule unit next to it already adds each schedule word to its round constant, so the engine takes one combined round word per round over a ready/valid handshake. The engine completes one round per clock cycle whenever a word is offered. After 64 rounds it adds the working variables into the chaining state, modulo 2^32, in one extra fold cycle.

A start strobe carries a block count. The engine chains that many blocks without being reloaded: after each fold it reloads a..h from the updated state. When round 48 of a block is reached, it has already taken one off the count of remaining blocks. From then until the block ends, a prefetch output tells the schedule unit whether to begin loading the next block.

The chaining state comes out of reset holding the standard SHA-256 initial hash values. While the engine is idle, software-facing logic can overwrite it one word at a time, and any word can be read back at any time. A one-cycle done pulse marks the end of the last block.

Top module: `sha256_chain_core`

## Requirements
- R1: After reset, busy, done, wk_ready and pref_next are 0. The state words 0..7 read 6a09e667, bb67ae85, 3c6ef372, a54ff53a, 510e527f, 9b05688c, 1f83d9ab and 5be0cd19. Word 0 is the word that seeds a, and word 7 seeds h.
- R2: While idle, a cycle with st_load high writes st_wdata into state word st_widx. st_rdata always shows state word st_ridx, combinationally.
- R3: Each round uses the incoming word X. It computes T1 = h + S1(e) + Ch(e,f,g) + X, with S1 the XOR of e rotated right by 6, 11 and 25, and Ch = (e&f)^(~e&g). The new a is T1 + S0(a) + Maj(a,b,c), with S0 the XOR of a rotated right by 2, 13 and 22, and Maj = (a&b)^(a&c)^(b&c). The new e is d + T1, and b,c,d,f,g,h take the old a,b,c,e,f,g. After 64 rounds, each state word i gains working variable i, modulo 2^32.
- R4: A round happens on exactly the clock edges where wk_valid and wk_ready are both high. A cycle with wk_valid low changes neither the working variables nor the final result.
- R5: A start with count N>0 processes N blocks, using 64·N words in total. Each block starts from the state left by the block before it.
- R6: pref_next is high during rounds 48..63 of a block exactly when at least one more block follows that block. It is low at every other time.
- R7: done is high for exactly one cycle, after the edge that folds the last block. busy is already low in that cycle.
- R8: A start with count 0 is ignored, and so is a start while busy. Neither one changes busy, done or the result.
- R9: st_load while busy is ignored and does not change the result.
- R10: wk_ready is high only while rounds are pending. It stays low for one fold cycle per block, so with no stalls done appears 65·N edges after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job (idle only) |
| blk_count | input | CNT_W | Number of blocks in the job |
| wk_valid | input | 1 | Combined round word is offered |
| wk_data | input | 32 | Schedule word plus round constant |
| wk_ready | output | 1 | Engine takes a word this cycle |
| st_load | input | 1 | Write one state word (idle only) |
| st_widx | input | 3 | Index of the word to write |
| st_wdata | input | 32 | Value to write |
| st_ridx | input | 3 | Index of the word to read |
| st_rdata | output | 32 | Selected state word |
| pref_next | output | 1 | Next block's words may be prefetched |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |

## Verification
A wrong working variable, such as a mixed-up rotation or a misrouted d-to-e shift, stays invisible until the fold. It then spreads into every state word that the bench reads back, so it shows within 65 cycles of the block's first word. A control fault shows up earlier and more precisely. A wrong round count or a missing fold cycle moves the done edge away from 65·N plus the stall count. A wrong block-counter decrement turns pref_next on or off in the wrong round of the first affected block.

// File: rtl/sha256_chain_pkg.sv
package sha256_chain_pkg;

    localparam int WORD_W = 32;
    localparam int NWORDS = 8;
    localparam int IDX_W  = $clog2(NWORDS);
    localparam int ROUNDS = 64;
    localparam int RND_W  = $clog2(ROUNDS);
    localparam int PREF_ROUND = 48;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [NWORDS-1:0][WORD_W-1:0] words_t;

    typedef struct packed {
        word_t a; word_t b; word_t c; word_t d;
        word_t e; word_t f; word_t g; word_t h;
    } vars_t;

    typedef enum logic [1:0] {PH_IDLE, PH_RUN, PH_FOLD} phase_t;

    localparam words_t HASH_IV = {
        32'h5be0cd19, 32'h1f83d9ab, 32'h9b05688c, 32'h510e527f,
        32'ha54ff53a, 32'h3c6ef372, 32'hbb67ae85, 32'h6a09e667
    };

    function automatic word_t rotr(word_t x, int n);
        return (x >> n) | (x << (WORD_W - n));
    endfunction

    function automatic word_t big_s0(word_t x);
        return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
    endfunction

    function automatic word_t big_s1(word_t x);
        return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
    endfunction

    function automatic word_t pick(word_t x, word_t y, word_t z);
        return (x & y) ^ (~x & z);
    endfunction

    function automatic word_t vote(word_t x, word_t y, word_t z);
        return (x & y) ^ (x & z) ^ (y & z);
    endfunction

    function automatic vars_t words_to_vars(words_t w);
        vars_t v;
        v.a = w[0]; v.b = w[1]; v.c = w[2]; v.d = w[3];
        v.e = w[4]; v.f = w[5]; v.g = w[6]; v.h = w[7];
        return v;
    endfunction

    function automatic words_t vars_to_words(vars_t v);
        words_t w;
        w[0] = v.a; w[1] = v.b; w[2] = v.c; w[3] = v.d;
        w[4] = v.e; w[5] = v.f; w[6] = v.g; w[7] = v.h;
        return w;
    endfunction

endpackage

// File: rtl/sha256_round.sv
module sha256_round
    import sha256_chain_pkg::*;
(
    input  vars_t cur,
    input  word_t wk,
    output vars_t nxt
);
    word_t t1;
    word_t t2;

    always_comb begin
        t1 = cur.h + big_s1(cur.e) + pick(cur.e, cur.f, cur.g) + wk;
        t2 = big_s0(cur.a) + vote(cur.a, cur.b, cur.c);
        nxt.a = t1 + t2;
        nxt.b = cur.a;
        nxt.c = cur.b;
        nxt.d = cur.c;
        nxt.e = cur.d + t1;
        nxt.f = cur.e;
        nxt.g = cur.f;
        nxt.h = cur.g;
    end
endmodule

// File: rtl/sha256_state_file.sv
module sha256_state_file
    import sha256_chain_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [IDX_W-1:0] load_idx,
    input  word_t            load_data,
    input  logic             fold_en,
    input  words_t           vin,
    input  logic [IDX_W-1:0] rd_idx,
    output word_t            rd_data,
    output words_t           words,
    output words_t           sum
);
    words_t st_d, st_q;

    for (genvar i = 0; i < NWORDS; i++) begin : g_fold_add
        assign sum[i] = st_q[i] + vin[i];
    end

    always_comb begin
        st_d = st_q;
        if (fold_en)
            st_d = sum;
        else if (load_en)
            st_d[load_idx] = load_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= HASH_IV;
        else        st_q <= st_d;
    end

    assign rd_data = st_q[rd_idx];
    assign words   = st_q;

    AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!fold_en && !load_en) |=> $stable(st_q)); // R9
endmodule

// File: rtl/sha256_ctrl.sv
module sha256_ctrl
    import sha256_chain_pkg::*;
#(
    parameter int CNT_W = 8
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] blk_count,
    input  logic             wk_valid,
    output logic             wk_ready,
    output logic             step,
    output logic             fold_en,
    output logic             begin_job,
    output logic             pref_next,
    output logic             busy,
    output logic             done
);
    typedef struct packed {
        phase_t           ph;
        logic [RND_W-1:0] rnd;
        logic [CNT_W-1:0] left;
        logic             done;
    } ctl_t;

    ctl_t c_d, c_q;

    localparam logic [RND_W-1:0] LAST_RND = RND_W'(ROUNDS - 1);
    localparam logic [RND_W-1:0] DEC_RND  = RND_W'(PREF_ROUND - 1);
    localparam logic [RND_W-1:0] PRF_RND  = RND_W'(PREF_ROUND);

    assign begin_job = (c_q.ph == PH_IDLE) && start && (blk_count != '0);
    assign wk_ready  = (c_q.ph == PH_RUN);
    assign step      = wk_ready && wk_valid;
    assign fold_en   = (c_q.ph == PH_FOLD);
    assign pref_next = wk_ready && (c_q.rnd >= PRF_RND) && (c_q.left != '0);
    assign busy      = (c_q.ph != PH_IDLE);
    assign done      = c_q.done;

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        unique case (c_q.ph)
            PH_IDLE: begin
                if (begin_job) begin
                    c_d.ph   = PH_RUN;
                    c_d.rnd  = '0;
                    c_d.left = blk_count;
                end
            end
            PH_RUN: begin
                if (wk_valid) begin
                    c_d.rnd = c_q.rnd + 1'b1;
                    if (c_q.rnd == DEC_RND)  c_d.left = c_q.left - 1'b1;
                    if (c_q.rnd == LAST_RND) c_d.ph = PH_FOLD;
                end
            end
            PH_FOLD: begin
                c_d.rnd = '0;
                if (c_q.left == '0) begin
                    c_d.ph   = PH_IDLE;
                    c_d.done = 1'b1;
                end else begin
                    c_d.ph = PH_RUN;
                end
            end
            default: c_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.ph   <= PH_IDLE;
            c_q.rnd  <= '0;
            c_q.left <= '0;
            c_q.done <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R7
    AST_FOLD_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        fold_en |-> ($past(step) && $past(c_q.rnd) == LAST_RND)); // R3
    AST_PREF_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        pref_next |-> (busy && c_q.rnd >= PRF_RND)); // R6
    AST_LEFT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (wk_ready && c_q.rnd < PRF_RND) |-> (c_q.left != '0)); // R5
endmodule

// File: rtl/sha256_chain_core.sv
module sha256_chain_core
    import sha256_chain_pkg::*;
#(
    parameter int CNT_W = 8
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] blk_count,
    input  logic             wk_valid,
    input  logic [31:0]      wk_data,
    output logic             wk_ready,
    input  logic             st_load,
    input  logic [2:0]       st_widx,
    input  logic [31:0]      st_wdata,
    input  logic [2:0]       st_ridx,
    output logic [31:0]      st_rdata,
    output logic             pref_next,
    output logic             busy,
    output logic             done
);
    logic   step, fold_en, begin_job;
    vars_t  vars_d, vars_q, rnd_out;
    words_t st_words, st_sum;

    sha256_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .blk_count(blk_count),
        .wk_valid(wk_valid), .wk_ready(wk_ready), .step(step),
        .fold_en(fold_en), .begin_job(begin_job), .pref_next(pref_next),
        .busy(busy), .done(done)
    );

    sha256_round u_round (
        .cur(vars_q), .wk(wk_data), .nxt(rnd_out)
    );

    sha256_state_file u_state (
        .clk(clk), .rst_n(rst_n),
        .load_en(st_load && !busy), .load_idx(st_widx), .load_data(st_wdata),
        .fold_en(fold_en), .vin(vars_to_words(vars_q)),
        .rd_idx(st_ridx), .rd_data(st_rdata),
        .words(st_words), .sum(st_sum)
    );

    always_comb begin
        vars_d = vars_q;
        if (begin_job)
            vars_d = words_to_vars(st_words);
        else if (step)
            vars_d = rnd_out;
        else if (fold_en)
            vars_d = words_to_vars(st_sum);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) vars_q <= '0;
        else        vars_q <= vars_d;
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wk_ready && !wk_valid) |=> $stable(vars_q)); // R4
    AST_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wk_ready |-> busy); // R10
    AST_ROUND_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (vars_q.b == $past(vars_q.a) && vars_q.f == $past(vars_q.e))); // R3
endmodule

// File: tb/sha256_chain_core_test.sv
module sha256_chain_core_test;
    localparam int CNT_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [CNT_W-1:0] blk_count = '0;
    logic wk_valid = 1'b0;
    logic [31:0] wk_data = '0;
    logic wk_ready;
    logic st_load = 1'b0;
    logic [2:0] st_widx = '0;
    logic [31:0] st_wdata = '0;
    logic [2:0] st_ridx = '0;
    logic [31:0] st_rdata;
    logic pref_next, busy, done;

    int checks = 0;
    int failures = 0;
    logic [31:0] exp_st [8];

    always #10 clk = ~clk;

    sha256_chain_core #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .blk_count(blk_count),
        .wk_valid(wk_valid), .wk_data(wk_data), .wk_ready(wk_ready),
        .st_load(st_load), .st_widx(st_widx), .st_wdata(st_wdata),
        .st_ridx(st_ridx), .st_rdata(st_rdata),
        .pref_next(pref_next), .busy(busy), .done(done)
    );

    initial begin
        #4000000;
        checks++; failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ror(logic [31:0] x, int n);
        return (x >> n) | (x << (32 - n));
    endfunction

    function automatic logic [31:0] gen_word(int k, int seed);
        logic [31:0] x;
        x = 32'(k) * 32'h85ebca6b ^ 32'(seed) * 32'h9e3779b9;
        return x ^ (x >> 13) ^ (32'(k) << 7);
    endfunction

    task automatic model(int n, int seed);
        logic [31:0] v [8];
        logic [31:0] t1, t2;
        for (int b = 0; b < n; b++) begin
            for (int i = 0; i < 8; i++) v[i] = exp_st[i];
            for (int r = 0; r < 64; r++) begin
                t1 = v[7] + (ror(v[4],6) ^ ror(v[4],11) ^ ror(v[4],25))
                   + ((v[4] & v[5]) ^ (~v[4] & v[6])) + gen_word(b*64 + r, seed);
                t2 = (ror(v[0],2) ^ ror(v[0],13) ^ ror(v[0],22))
                   + ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
                v[7] = v[6]; v[6] = v[5]; v[5] = v[4]; v[4] = v[3] + t1;
                v[3] = v[2]; v[2] = v[1]; v[1] = v[0]; v[0] = t1 + t2;
            end
            for (int i = 0; i < 8; i++) exp_st[i] = exp_st[i] + v[i];
        end
    endtask

    task automatic check_state(string req);
        for (int i = 0; i < 8; i++) begin
            st_ridx = 3'(i);
            #1;
            check(req, st_rdata, exp_st[i]);
        end
    endtask

    task automatic run_job(int n, int mode, int seed, bit disturb);
        int edges, stalls, idle_cyc, k, pref_bad;
        bit exp_pref;
        model(n, seed);
        @(negedge clk);
        start = 1'b1; blk_count = CNT_W'(n);
        @(negedge clk);
        start = 1'b0;
        edges = 0; stalls = 0; idle_cyc = 0; k = 0; pref_bad = 0;
        while (!done && edges < 2000) begin
            if (wk_ready) begin
                exp_pref = ((k % 64) >= 48) && ((k / 64) < n - 1);
                if (pref_next !== exp_pref) pref_bad++;
            end else begin
                if (pref_next !== 1'b0) pref_bad++;
                idle_cyc++;
            end
            wk_valid = !(mode != 0 && ((edges * 7 + mode) % 5 == 0)) && (k < n * 64);
            wk_data  = wk_valid ? gen_word(k, seed) : 32'hdeadbeef;
            if (wk_ready && !wk_valid) stalls++;
            if (disturb && edges == 30) begin
                st_load = 1'b1; st_widx = 3'd3; st_wdata = 32'h0badf00d;
                start = 1'b1; blk_count = 8'd5;
            end else if (disturb && edges == 100) begin
                st_load = 1'b1; st_widx = 3'd0; st_wdata = 32'h12345678;
                start = 1'b0;
            end else begin
                st_load = 1'b0; start = 1'b0;
            end
            if (wk_valid && wk_ready) k++;
            @(negedge clk);
            edges++;
        end
        wk_valid = 1'b0; st_load = 1'b0; start = 1'b0;
        check("R10 done edge count", 32'(edges), 32'(65 * n + stalls));
        check("R10 fold cycles with ready low", 32'(idle_cyc), 32'(n));
        check("R5 words consumed", 32'(k), 32'(n * 64));
        check("R6 prefetch mismatches", 32'(pref_bad), 32'd0);
        check("R7 busy low at done", {31'd0, busy}, 32'd0);
        check_state(disturb ? "R8 R9 result despite start/load while busy"
                            : (mode != 0 ? "R4 result with stalls" : "R3 R5 result"));
        @(negedge clk);
        check("R7 done one cycle", {31'd0, done}, 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) exp_st[i] = 32'h0;
        exp_st[0] = 32'h6a09e667; exp_st[1] = 32'hbb67ae85;
        exp_st[2] = 32'h3c6ef372; exp_st[3] = 32'ha54ff53a;
        exp_st[4] = 32'h510e527f; exp_st[5] = 32'h9b05688c;
        exp_st[6] = 32'h1f83d9ab; exp_st[7] = 32'h5be0cd19;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 busy", {31'd0, busy}, 32'd0);
        check("R1 done", {31'd0, done}, 32'd0);
        check("R1 wk_ready", {31'd0, wk_ready}, 32'd0);
        check("R1 pref_next", {31'd0, pref_next}, 32'd0);
        check_state("R1 initial hash words");

        // R8 zero-count start is ignored
        start = 1'b1; blk_count = '0;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 4; i++) begin
            check("R8 zero count busy", {31'd0, busy}, 32'd0);
            check("R8 zero count done", {31'd0, done}, 32'd0);
            @(negedge clk);
        end
        check_state("R8 zero count state");

        run_job(1, 0, 1, 1'b0);

        // R2 load while idle and read back
        for (int i = 0; i < 8; i++) begin
            st_load = 1'b1; st_widx = 3'(i);
            st_wdata = 32'h01020304 * 32'(i + 1) ^ 32'hc3a5_0f96;
            exp_st[i] = st_wdata;
            @(negedge clk);
        end
        st_load = 1'b0;
        check_state("R2 loaded words");

        run_job(2, 1, 2, 1'b0);
        run_job(3, 2, 3, 1'b1);

        for (int n = 1; n <= 4; n++)
            for (int m = 0; m < 4; m++)
                run_job(n, m, 10 + n * 4 + m, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule